// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface. After reset it drives the clock enable, the four command lines, the bank select and the address/opcode bus through the fixed bring-up sequence the memory needs. It keeps clock enable low through a long stable-clock delay. It then raises clock enable with a NOP and issues these commands in order: a precharge of every bank, an extended mode write that turns the DLL on, and a mode write that resets the DLL and loads the operating settings. A second precharge of every bank follows, then a programmable number of auto refreshes, and finally a mode write that keeps the settings without resetting the DLL.

Each command is followed by NOP cycles until its own recovery time has passed. The ready flag rises only when two conditions hold: the last mode write's recovery has elapsed, and enough cycles have passed since the DLL reset for reads to be legal. Every wait length is an elaboration parameter, so a simulation can use short values. Burst length, burst type, CAS latency and output drive strength are parameters that are folded into the opcodes. Normal traffic and refresh scheduling after bring-up belong to other blocks, which wait for the ready flag.

Top module: `ddr_pwrup_seq`

## Requirements
- R1: While reset is held, and afterwards until the STABLE_CYC-th rising clock edge after reset release, `cke` is 0, `init_done` is 0 and the command lines show NOP. `cke` becomes 1 at exactly that edge, with a NOP on the bus. Asserting reset at any time returns `cke` and `init_done` to 0 at once.
- R2: Command codes on {`cs_n`,`ras_n`,`cas_n`,`we_n`} are NOP = 0111, precharge = 0010, auto refresh = 0001 and mode write = 0000. No other code ever appears, and NOP is driven on every cycle that carries no sequence command.
- R3: The non-NOP commands appear in this order: precharge, extended mode write, mode write with DLL reset, precharge, REFRESHES auto refreshes, mode write without DLL reset.
- R4: Both precharge commands carry `addr[10]` = 1 so that all banks close, with every other address bit and `ba` at 0.
- R5: The extended mode write uses `ba` = 01 and `addr[0]` = 0 (DLL enabled). Drive strength is placed on `addr[1]` and `addr[6]`: full = both 0, half = `addr[1]` only, matched = both 1. All other bits are 0.
- R6: Both mode writes use `ba` = 00. Burst length code log2(BURST_LEN) goes on `addr[2:0]`, burst type (1 = interleaved) on `addr[3]` and the CAS latency value on `addr[6:4]`. `addr[8]` is 1 on the first mode write and 0 on the last, and all other bits are 0.
- R7: The spacing between consecutive commands is counted in clock edges. It is CKE_TO_CMD from the clock-enable NOP to the first precharge, TRP_CYC after each precharge, TMRD_CYC after each mode write, and TRFC_CYC after each auto refresh. No command is ever followed directly by another.
- R8: `init_done` rises at the later of two edges: TMRD_CYC edges after the final mode write, or DLL_LOCK_CYC edges after the DLL-reset mode write. Once high it stays high, and from then on only NOP is driven.
- R9: Exactly REFRESHES auto refresh commands are issued, and the parameter is at least 2.
- R10: Once `cke` has risen it stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock; all outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe command line, active low |
| cas_n | output | 1 | Column strobe command line, active low |
| we_n | output | 1 | Write enable command line, active low |
| ba | output | 2 | Bank select; picks the mode register during mode writes |
| addr | output | ADDR_W | Address / opcode bus |
| init_done | output | 1 | Sequence complete; normal traffic may begin |

## Verification
On every cycle, the bound checker enforces the local rules. These are: NOP while clock enable is low, the legal command set, a NOP after every command, all-bank precharge, DLL enable in the extended write, and clock enable and ready both staying high once set. It also confirms, with its own counters, that clock enable rose after the full stable delay and that ready never rose before the DLL lock count was reached. The global order of the sequence, the exact edge of each command, the opcode contents for different burst, latency and drive settings, and which limit decides the ready edge can only be shown by the bench. It runs three configurations side by side and compares their logged command traces against schedules computed from the parameters.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_MRS  = 4'b0000,
      CMD_AREF = 4'b0001,
      CMD_PRE  = 4'b0010,
      CMD_NOP  = 4'b0111
   } ddr_cmd_e;

   // Step names the command that is issued next
   typedef enum logic [3:0] {
      ST_WAKE,
      ST_PRE_FIRST,
      ST_EXT_MODE,
      ST_MODE_DLL,
      ST_PRE_SECOND,
      ST_REFRESH,
      ST_MODE_RUN,
      ST_SETTLE,
      ST_READY
   } init_step_e;

   localparam int AP_BIT      = 10;
   localparam int DLL_RST_BIT = 8;
   localparam int DLL_OFF_BIT = 0;
   localparam int DRV_LO_BIT  = 1;
   localparam int DRV_HI_BIT  = 6;
   localparam int BT_BIT      = 3;
   localparam int CL_LSB      = 4;
   localparam int BL_LSB      = 0;

   localparam logic [1:0] BANK_MODE = 2'b00;
   localparam logic [1:0] BANK_EXT  = 2'b01;

   function automatic int larger(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ddr_init_opcode.sv
module ddr_init_opcode
   import ddr_init_pkg::*;
#(
   parameter int ADDR_W     = 13,
   parameter int CAS_LAT    = 3,
   parameter int BURST_LEN  = 4,
   parameter int INTERLEAVE = 0,
   parameter int DRIVE      = 0
) (
   output logic [ADDR_W-1:0] mode_word,
   output logic [ADDR_W-1:0] ext_word
);

   logic [2:0] bl_code;
   logic [2:0] cl_code;
   logic [1:0] drv_bits;

   generate
      case (BURST_LEN)
         2:       begin : g_bl2 assign bl_code = 3'b001; end
         4:       begin : g_bl4 assign bl_code = 3'b010; end
         8:       begin : g_bl8 assign bl_code = 3'b011; end
         default: begin : g_bl_bad
            $error("burst length must be 2, 4 or 8");
            assign bl_code = 3'b000;
         end
      endcase

      case (CAS_LAT)
         3, 4:    begin : g_cl_ok assign cl_code = 3'(CAS_LAT); end
         default: begin : g_cl_bad
            $error("CAS latency must be 3 or 4");
            assign cl_code = 3'b000;
         end
      endcase

      case (DRIVE)
         0:       begin : g_drv_full    assign drv_bits = 2'b00; end
         1:       begin : g_drv_half    assign drv_bits = 2'b01; end
         2:       begin : g_drv_matched assign drv_bits = 2'b11; end
         default: begin : g_drv_bad
            $error("drive selection must be 0, 1 or 2");
            assign drv_bits = 2'b00;
         end
      endcase
   endgenerate

   always_comb begin
      mode_word                      = '0;
      mode_word[BL_LSB+2:BL_LSB]     = bl_code;
      mode_word[BT_BIT]              = (INTERLEAVE != 0);
      mode_word[CL_LSB+2:CL_LSB]     = cl_code;
   end

   always_comb begin
      ext_word              = '0;
      ext_word[DLL_OFF_BIT] = 1'b0;
      ext_word[DRV_LO_BIT]  = drv_bits[0];
      ext_word[DRV_HI_BIT]  = drv_bits[1];
   end

endmodule

// File: rtl/ddr_init_gap_timer.sv
module ddr_init_gap_timer #(
   parameter int              CNT_W     = 8,
   parameter logic [CNT_W-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= RESET_VAL;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/ddr_init_dll_watch.sv
module ddr_init_dll_watch #(
   parameter int LOCK_CYC = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic lock_next
);

   localparam int             W     = $clog2(LOCK_CYC + 1);
   localparam logic [W-1:0]   LIMIT = W'(LOCK_CYC);
   localparam logic [W-1:0]   LAST  = W'(LOCK_CYC - 1);

   logic         armed_q;
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (start) begin
         armed_q <= 1'b1;
         cnt_q   <= '0;
      end else if (armed_q && cnt_q < LIMIT) begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   // true when the coming edge is at least LOCK_CYC edges after start
   assign lock_next = armed_q && (cnt_q >= LAST);

endmodule

// File: rtl/ddr_init_pin_drive.sv
module ddr_init_pin_drive
   import ddr_init_pkg::*;
#(
   parameter int ADDR_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic              cke_on,
   input  logic              done_set,
   input  ddr_cmd_e          cmd_in,
   input  logic [1:0]        bank_in,
   input  logic [ADDR_W-1:0] addr_in,
   output logic              cke,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [1:0]        ba,
   output logic [ADDR_W-1:0] addr,
   output logic              done
);

   ddr_cmd_e          cmd_q;
   logic [1:0]        ba_q;
   logic [ADDR_W-1:0] addr_q;
   logic              cke_q;
   logic              done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= CMD_NOP;
         ba_q   <= '0;
         addr_q <= '0;
         cke_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         if (issue) begin
            cmd_q  <= cmd_in;
            ba_q   <= bank_in;
            addr_q <= addr_in;
         end else begin
            cmd_q  <= CMD_NOP;
            ba_q   <= '0;
            addr_q <= '0;
         end
         cke_q  <= cke_q | cke_on;
         done_q <= done_q | done_set;
      end
   end

   assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
   assign ba   = ba_q;
   assign addr = addr_q;
   assign cke  = cke_q;
   assign done = done_q;

endmodule

// File: rtl/ddr_pwrup_seq.sv
module ddr_pwrup_seq
   import ddr_init_pkg::*;
#(
   parameter int ADDR_W       = 13,
   parameter int STABLE_CYC   = 40000,
   parameter int CKE_TO_CMD   = 2,
   parameter int TRP_CYC      = 3,
   parameter int TMRD_CYC     = 2,
   parameter int TRFC_CYC     = 12,
   parameter int REFRESHES    = 2,
   parameter int DLL_LOCK_CYC = 200,
   parameter int CAS_LAT      = 3,
   parameter int BURST_LEN    = 4,
   parameter int INTERLEAVE   = 0,
   parameter int DRIVE        = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              cke,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [1:0]        ba,
   output logic [ADDR_W-1:0] addr,
   output logic              init_done
);

   localparam int MAX_WAIT = larger(larger(STABLE_CYC, CKE_TO_CMD),
                                    larger(larger(TRP_CYC, TMRD_CYC), TRFC_CYC));
   localparam int CNT_W    = $clog2(MAX_WAIT + 1);
   localparam int REF_W    = $clog2(REFRESHES + 1);

   localparam logic [CNT_W-1:0] GAP_STABLE = CNT_W'(STABLE_CYC - 1);
   localparam logic [CNT_W-1:0] GAP_CKE    = CNT_W'(CKE_TO_CMD - 1);
   localparam logic [CNT_W-1:0] GAP_RP     = CNT_W'(TRP_CYC - 1);
   localparam logic [CNT_W-1:0] GAP_MRD    = CNT_W'(TMRD_CYC - 1);
   localparam logic [CNT_W-1:0] GAP_RFC    = CNT_W'(TRFC_CYC - 1);
   localparam logic [REF_W-1:0] REF_TOTAL  = REF_W'(REFRESHES);

   generate
      if (ADDR_W < 11) begin : g_chk_addr
         $error("address bus must reach bit 10");
      end
      if (STABLE_CYC < 1 || DLL_LOCK_CYC < 1) begin : g_chk_long
         $error("stable and lock counts must be positive");
      end
      if (CKE_TO_CMD < 2 || TRP_CYC < 2 || TMRD_CYC < 2 || TRFC_CYC < 2) begin : g_chk_gap
         $error("command spacings must be at least two cycles");
      end
      if (REFRESHES < 2) begin : g_chk_ref
         $error("at least two refreshes are required");
      end
   endgenerate

   init_step_e        step_q, step_d;
   logic [REF_W-1:0]  ref_left_q;
   logic              ref_load, ref_dec;

   logic              gap_zero, issue;
   logic [CNT_W-1:0]  gap_val;
   logic              lock_next, dll_start;
   logic              cke_on, done_set;

   ddr_cmd_e          nx_cmd;
   logic [1:0]        nx_bank;
   logic [ADDR_W-1:0] nx_addr;

   logic [ADDR_W-1:0] mode_word, ext_word;
   logic [ADDR_W-1:0] all_banks;

   always_comb begin
      all_banks         = '0;
      all_banks[AP_BIT] = 1'b1;
   end

   ddr_init_opcode #(
      .ADDR_W     (ADDR_W),
      .CAS_LAT    (CAS_LAT),
      .BURST_LEN  (BURST_LEN),
      .INTERLEAVE (INTERLEAVE),
      .DRIVE      (DRIVE)
   ) u_opcode (
      .mode_word  (mode_word),
      .ext_word   (ext_word)
   );

   ddr_init_gap_timer #(
      .CNT_W     (CNT_W),
      .RESET_VAL (GAP_STABLE)
   ) u_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (issue),
      .load_val (gap_val),
      .expired  (gap_zero)
   );

   ddr_init_dll_watch #(
      .LOCK_CYC (DLL_LOCK_CYC)
   ) u_dll (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (dll_start),
      .lock_next (lock_next)
   );

   always_comb begin
      step_d    = step_q;
      issue     = 1'b0;
      nx_cmd    = CMD_NOP;
      nx_bank   = '0;
      nx_addr   = '0;
      gap_val   = '0;
      cke_on    = 1'b0;
      dll_start = 1'b0;
      done_set  = 1'b0;
      ref_load  = 1'b0;
      ref_dec   = 1'b0;
      unique case (step_q)
         ST_WAKE: if (gap_zero) begin
            issue   = 1'b1;
            cke_on  = 1'b1;
            gap_val = GAP_CKE;
            step_d  = ST_PRE_FIRST;
         end
         ST_PRE_FIRST: if (gap_zero) begin
            issue   = 1'b1;
            nx_cmd  = CMD_PRE;
            nx_addr = all_banks;
            gap_val = GAP_RP;
            step_d  = ST_EXT_MODE;
         end
         ST_EXT_MODE: if (gap_zero) begin
            issue   = 1'b1;
            nx_cmd  = CMD_MRS;
            nx_bank = BANK_EXT;
            nx_addr = ext_word;
            gap_val = GAP_MRD;
            step_d  = ST_MODE_DLL;
         end
         ST_MODE_DLL: if (gap_zero) begin
            issue     = 1'b1;
            nx_cmd    = CMD_MRS;
            nx_bank   = BANK_MODE;
            nx_addr   = mode_word;
            nx_addr[DLL_RST_BIT] = 1'b1;
            gap_val   = GAP_MRD;
            dll_start = 1'b1;
            step_d    = ST_PRE_SECOND;
         end
         ST_PRE_SECOND: if (gap_zero) begin
            issue    = 1'b1;
            nx_cmd   = CMD_PRE;
            nx_addr  = all_banks;
            gap_val  = GAP_RP;
            ref_load = 1'b1;
            step_d   = ST_REFRESH;
         end
         ST_REFRESH: if (gap_zero) begin
            issue   = 1'b1;
            nx_cmd  = CMD_AREF;
            gap_val = GAP_RFC;
            ref_dec = 1'b1;
            if (ref_left_q == REF_W'(1)) step_d = ST_MODE_RUN;
         end
         ST_MODE_RUN: if (gap_zero) begin
            issue   = 1'b1;
            nx_cmd  = CMD_MRS;
            nx_bank = BANK_MODE;
            nx_addr = mode_word;
            gap_val = GAP_MRD;
            step_d  = ST_SETTLE;
         end
         ST_SETTLE: if (gap_zero && lock_next) begin
            done_set = 1'b1;
            step_d   = ST_READY;
         end
         ST_READY: ;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q     <= ST_WAKE;
         ref_left_q <= '0;
      end else begin
         step_q <= step_d;
         if (ref_load)     ref_left_q <= REF_TOTAL;
         else if (ref_dec) ref_left_q <= ref_left_q - 1'b1;
      end
   end

   ddr_init_pin_drive #(
      .ADDR_W (ADDR_W)
   ) u_pins (
      .clk      (clk),
      .rst_n    (rst_n),
      .issue    (issue),
      .cke_on   (cke_on),
      .done_set (done_set),
      .cmd_in   (nx_cmd),
      .bank_in  (nx_bank),
      .addr_in  (nx_addr),
      .cke      (cke),
      .cs_n     (cs_n),
      .ras_n    (ras_n),
      .cas_n    (cas_n),
      .we_n     (we_n),
      .ba       (ba),
      .addr     (addr),
      .done     (init_done)
   );

endmodule

// File: rtl/ddr_pwrup_seq_chk.sv
module ddr_pwrup_seq_chk #(
   parameter int ADDR_W       = 13,
   parameter int STABLE_CYC   = 40000,
   parameter int DLL_LOCK_CYC = 200
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cke,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [1:0]        ba,
   input logic [ADDR_W-1:0] addr,
   input logic              init_done
);

   localparam int LW = $clog2(STABLE_CYC + 2);
   localparam int DW = $clog2(DLL_LOCK_CYC + 2);
   localparam logic [LW-1:0] LOW_CAP = LW'(STABLE_CYC + 1);
   localparam logic [DW-1:0] DLL_CAP = DW'(DLL_LOCK_CYC + 1);

   logic [3:0] cmd;
   assign cmd = {cs_n, ras_n, cas_n, we_n};

   logic [LW-1:0] low_cnt;
   logic [DW-1:0] dll_cnt;
   logic          dll_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          low_cnt <= '0;
      else if (!cke && low_cnt < LOW_CAP)  low_cnt <= low_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dll_seen <= 1'b0;
         dll_cnt  <= '0;
      end else if (!dll_seen && cmd == 4'b0000 && ba == 2'b00 && addr[8]) begin
         dll_seen <= 1'b1;
         dll_cnt  <= DW'(1);
      end else if (dll_seen && dll_cnt < DLL_CAP) begin
         dll_cnt  <= dll_cnt + 1'b1;
      end
   end

   p_cke_low_nop_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |-> cmd == 4'b0111);

   p_wake_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke) |-> low_cnt == LW'(STABLE_CYC));

   p_legal_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == 4'b0111 || cmd == 4'b0010 || cmd == 4'b0001 || cmd == 4'b0000);

   p_all_banks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == 4'b0010 |-> addr[10]);

   p_ext_dll_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 4'b0000 && ba == 2'b01) |-> !addr[0]);

   p_single_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd != 4'b0111 |=> cmd == 4'b0111);

   p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);

   p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> (cke && cmd == 4'b0111));

   p_done_after_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> (dll_seen && dll_cnt >= DW'(DLL_LOCK_CYC)));

   p_cke_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cke |=> cke);

endmodule

bind ddr_pwrup_seq ddr_pwrup_seq_chk #(
   .ADDR_W       (ADDR_W),
   .STABLE_CYC   (STABLE_CYC),
   .DLL_LOCK_CYC (DLL_LOCK_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cke       (cke),
   .cs_n      (cs_n),
   .ras_n     (ras_n),
   .cas_n     (cas_n),
   .we_n      (we_n),
   .ba        (ba),
   .addr      (addr),
   .init_done (init_done)
);

// File: tb/ddr_pwrup_seq_test.sv
module ddr_pwrup_seq_log #(
   parameter int AW = 13
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cke,
   input logic          cs_n,
   input logic          ras_n,
   input logic          cas_n,
   input logic          we_n,
   input logic [1:0]    ba,
   input logic [AW-1:0] addr,
   input logic          done
);
   int cyc, n_ev, cke_rise, done_rise, idle_bad, post_done, cke_fall;
   int ev_cyc [16];
   int ev_code [16];
   logic [3:0] c;
   assign c = {cs_n, ras_n, cas_n, we_n};

   always @(negedge clk) begin
      if (!rst_n) begin
         cyc = 0; n_ev = 0; cke_rise = -1; done_rise = -1;
         idle_bad = 0; post_done = 0; cke_fall = 0;
      end else begin
         cyc++;
         if (!cke) begin
            if (cke_rise >= 0) cke_fall++;
            if (c != 4'b0111) idle_bad++;
         end else if (cke_rise < 0) begin
            cke_rise = cyc;
         end
         if (done && done_rise < 0) done_rise = cyc;
         if (c != 4'b0111) begin
            if (done) post_done++;
            if (n_ev < 16) begin
               ev_cyc[n_ev]  = cyc;
               ev_code[n_ev] = int'({c, ba, addr});
            end
            n_ev++;
         end
      end
   end
endmodule

module ddr_pwrup_seq_test;
   localparam int AW = 13;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 0;

   logic          cke_a, cs_a, ras_a, cas_a, we_a, done_a;
   logic [1:0]    ba_a;
   logic [AW-1:0] addr_a;
   logic          cke_b, cs_b, ras_b, cas_b, we_b, done_b;
   logic [1:0]    ba_b;
   logic [AW-1:0] addr_b;
   logic          cke_c, cs_c, ras_c, cas_c, we_c, done_c;
   logic [1:0]    ba_c;
   logic [AW-1:0] addr_c;

   // A: DLL lock decides ready; B: final tMRD decides ready; C: three refreshes
   ddr_pwrup_seq #(.ADDR_W(AW), .STABLE_CYC(20), .TRP_CYC(3), .TMRD_CYC(2),
      .TRFC_CYC(8), .REFRESHES(2), .DLL_LOCK_CYC(40), .CAS_LAT(3),
      .BURST_LEN(4), .INTERLEAVE(0), .DRIVE(0)) uut (
      .clk(clk), .rst_n(rst_n), .cke(cke_a), .cs_n(cs_a), .ras_n(ras_a),
      .cas_n(cas_a), .we_n(we_a), .ba(ba_a), .addr(addr_a), .init_done(done_a));

   ddr_pwrup_seq #(.ADDR_W(AW), .STABLE_CYC(12), .TRP_CYC(2), .TMRD_CYC(2),
      .TRFC_CYC(5), .REFRESHES(2), .DLL_LOCK_CYC(5), .CAS_LAT(3),
      .BURST_LEN(2), .INTERLEAVE(0), .DRIVE(1)) uut_b (
      .clk(clk), .rst_n(rst_n), .cke(cke_b), .cs_n(cs_b), .ras_n(ras_b),
      .cas_n(cas_b), .we_n(we_b), .ba(ba_b), .addr(addr_b), .init_done(done_b));

   ddr_pwrup_seq #(.ADDR_W(AW), .STABLE_CYC(30), .TRP_CYC(4), .TMRD_CYC(3),
      .TRFC_CYC(10), .REFRESHES(3), .DLL_LOCK_CYC(30), .CAS_LAT(4),
      .BURST_LEN(8), .INTERLEAVE(1), .DRIVE(2)) uut_c (
      .clk(clk), .rst_n(rst_n), .cke(cke_c), .cs_n(cs_c), .ras_n(ras_c),
      .cas_n(cas_c), .we_n(we_c), .ba(ba_c), .addr(addr_c), .init_done(done_c));

   ddr_pwrup_seq_log #(.AW(AW)) log_a (.clk(clk), .rst_n(rst_n), .cke(cke_a),
      .cs_n(cs_a), .ras_n(ras_a), .cas_n(cas_a), .we_n(we_a), .ba(ba_a),
      .addr(addr_a), .done(done_a));
   ddr_pwrup_seq_log #(.AW(AW)) log_b (.clk(clk), .rst_n(rst_n), .cke(cke_b),
      .cs_n(cs_b), .ras_n(ras_b), .cas_n(cas_b), .we_n(we_b), .ba(ba_b),
      .addr(addr_b), .done(done_b));
   ddr_pwrup_seq_log #(.AW(AW)) log_c (.clk(clk), .rst_n(rst_n), .cke(cke_c),
      .cs_n(cs_c), .ras_n(ras_c), .cas_n(cas_c), .we_n(we_c), .ba(ba_c),
      .addr(addr_c), .done(done_c));

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int code(input int cmd, input int bank, input int a);
      return (cmd << 15) | (bank << 13) | a;
   endfunction

   task automatic check_cfg(input string tag, input int s, input int p, input int m,
                            input int f, input int n, input int l, input int bl,
                            input int bt, input int cl, input int drv,
                            input int n_ev, input int ev_cyc[16], input int ev_code[16],
                            input int cke_rise, input int done_rise, input int idle_bad);
      int ecyc [16];
      int ecode [16];
      string ereq [16];
      int ne = 0;
      int t;
      int mrs1;
      int mode_w = $clog2(bl) | (bt << 3) | (cl << 4);
      int ext_w = ((drv >= 1) ? 2 : 0) | ((drv == 2) ? 64 : 0);
      t = s + 2;
      ecyc[ne] = t; ecode[ne] = code(2, 0, 1024); ereq[ne] = "R4"; ne++;
      t += p;
      ecyc[ne] = t; ecode[ne] = code(0, 1, ext_w); ereq[ne] = "R5"; ne++;
      t += m;
      ecyc[ne] = t; ecode[ne] = code(0, 0, mode_w | 256); ereq[ne] = "R6"; ne++;
      mrs1 = t;
      t += m;
      ecyc[ne] = t; ecode[ne] = code(2, 0, 1024); ereq[ne] = "R4"; ne++;
      t += p;
      for (int k = 0; k < n; k++) begin
         ecyc[ne] = t; ecode[ne] = code(1, 0, 0); ereq[ne] = "R2"; ne++;
         t += f;
      end
      ecyc[ne] = t; ecode[ne] = code(0, 0, mode_w); ereq[ne] = "R6"; ne++;
      t += m;
      chk("R1", {tag, " cke rise edge"}, cke_rise, s);
      chk("R1", {tag, " non-NOP while cke low"}, idle_bad, 0);
      chk("R9", {tag, " command count"}, n_ev, ne);
      for (int i = 0; i < ne && i < n_ev; i++) begin
         chk("R7", $sformatf("%s cmd%0d edge", tag, i), ev_cyc[i], ecyc[i]);
         chk("R3", $sformatf("%s cmd%0d code+bank", tag, i), ev_code[i] >> 13, ecode[i] >> 13);
         chk(ereq[i], $sformatf("%s cmd%0d address", tag, i), ev_code[i] & 8191, ecode[i] & 8191);
      end
      chk("R8", {tag, " ready edge"}, done_rise, (t > mrs1 + l) ? t : mrs1 + l);
   endtask

   task automatic t_reset_state();
      repeat (3) @(negedge clk);
      chk("R1", "A cke in reset", int'(cke_a), 0);
      chk("R1", "A done in reset", int'(done_a), 0);
      chk("R2", "A NOP in reset", int'({cs_a, ras_a, cas_a, we_a}), 7);
      chk("R1", "B cke in reset", int'(cke_b), 0);
      chk("R1", "C done in reset", int'(done_c), 0);
   endtask

   task automatic t_run_to_ready();
      bit all_done = 0;
      @(negedge clk); #1 rst_n = 1'b1;
      for (int i = 0; i < 400 && !all_done; i++) begin
         @(negedge clk); #1;
         all_done = done_a && done_b && done_c;
      end
      chk("R8", "all instances ready", int'(all_done), 1);
   endtask

   task automatic t_cfg_a();
      check_cfg("A", 20, 3, 2, 8, 2, 40, 4, 0, 3, 0, log_a.n_ev, log_a.ev_cyc,
                log_a.ev_code, log_a.cke_rise, log_a.done_rise, log_a.idle_bad);
   endtask

   task automatic t_cfg_b();
      check_cfg("B", 12, 2, 2, 5, 2, 5, 2, 0, 3, 1, log_b.n_ev, log_b.ev_cyc,
                log_b.ev_code, log_b.cke_rise, log_b.done_rise, log_b.idle_bad);
   endtask

   task automatic t_cfg_c();
      check_cfg("C", 30, 4, 3, 10, 3, 30, 8, 1, 4, 2, log_c.n_ev, log_c.ev_cyc,
                log_c.ev_code, log_c.cke_rise, log_c.done_rise, log_c.idle_bad);
   endtask

   task automatic t_quiet_hold();
      repeat (30) @(negedge clk);
      #1;
      chk("R8", "A commands after ready", log_a.post_done, 0);
      chk("R8", "C commands after ready", log_c.post_done, 0);
      chk("R8", "A ready held", int'(done_a), 1);
      chk("R10", "A cke drops", log_a.cke_fall, 0);
      chk("R10", "B cke drops", log_b.cke_fall, 0);
      chk("R10", "C cke held", int'(cke_c), 1);
   endtask

   task automatic t_reset_again();
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1", "A cke after late reset", int'(cke_a), 0);
      chk("R1", "A done after late reset", int'(done_a), 0);
      chk("R1", "C done after late reset", int'(done_c), 0);
   endtask

   initial begin
      t_reset_state();
      t_run_to_ready();
      t_cfg_a();
      t_cfg_b();
      t_cfg_c();
      t_quiet_hold();
      t_reset_again();
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      #100000;
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL R8 watchdog: actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule